// File: doc/BRIEF.md
# Double-Buffered Gamma Lookup Table

This block applies gamma correction to a pixel stream. Each incoming colour component is the address into a lookup table, and the red, green and blue fields of the addressed word replace the pixel. There are two table banks. The pixel path reads the live bank. Host writes into the table window always land in the other bank, the shadow bank. The table can therefore be rewritten while correction stays on, and correction never has to be turned off during an update.

Software controls the block through a small register space. Writes to the control register are staged. A commit strobe arms them, and they take effect at the next frame-start pulse, never inside a frame. To swap banks, software sets the update bit and commits. At the next frame start the two banks exchange roles, hardware clears the update bit, and the bank-index status bit toggles so that software can poll for completion. When the enable bit is clear, pixels pass through unchanged. The table depth is a parameter: 256 entries at 8 bits per component, or 1024 entries at 10 bits per component.

Top module: `gamma_lut_dbuf`

## Requirements
- R1: After reset the bank index (STAT offset 0x008 bit 0) reads 0, the control register (CTRL offset 0x000) reads 0, and the output valid is low.
- R2: While the live enable is 0, each output pixel equals the input pixel on all three components (bypass).
- R3: A write to byte address 0x2000 + 4*i stores entry i in the shadow bank only, so pixels corrected from the live bank do not change.
- R4: Writing CTRL with bit 1 set raises the update bit. The bit reads 1 until the swap is carried out and reads 0 afterwards. Writing 0 to bit 1 does not clear it.
- R5: When a committed update is applied, the bank index toggles and the pixel path reads from the other bank.
- R6: CTRL writes (bit 0 enable, bit 1 update) have no effect on the pixel path until a write of bit 0 = 1 to CFG (offset 0x004) commits them and a frame-start pulse follows. The commit on its own has no visible effect.
- R7: While enabled, the output red, green and blue values are the fields [3*BPC-1:2*BPC], [2*BPC-1:BPC] and [BPC-1:0] of the live-bank words addressed by the input red, green and blue.
- R8: The output valid, hsync and vsync equal the input values one clock earlier, aligned with the pixel data they travel with.
- R9: LUT_DEPTH is 256 (BPC 8) or 1024 (BPC 10), and any other value is rejected at elaboration. The last entry, DEPTH-1, is addressable.
- R10: A frame-start pulse without a prior commit changes neither the bank index nor the update bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register or table write strobe |
| reg_waddr_i | input | ADDR_W | Write byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Register read strobe |
| reg_raddr_i | input | ADDR_W | Read byte address |
| reg_rdata_o | output | 32 | Read data, one cycle after the read strobe |
| frame_start_i | input | 1 | Frame boundary pulse |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_hs_i | input | 1 | Input horizontal sync |
| pix_vs_i | input | 1 | Input vertical sync |
| pix_r_i | input | BPC | Input red |
| pix_g_i | input | BPC | Input green |
| pix_b_i | input | BPC | Input blue |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_hs_o | output | 1 | Output horizontal sync |
| pix_vs_o | output | 1 | Output vertical sync |
| pix_r_o | output | BPC | Output red |
| pix_g_o | output | BPC | Output green |
| pix_b_o | output | BPC | Output blue |

## Verification
The assertions assume that frame_start_i is a single-cycle pulse, and that a register write never collides with a frame-start pulse in the same cycle. Under that assumption a change of bank or enable can always be traced to the pulse one cycle earlier. The bypass assertion assumes the input pixel is sampled in the same cycle as the enable it is judged against. The stimulus drives frame pulses, commits and table writes as separate, non-overlapping steps. It sends pixels only after a frame pulse has completed, so the live state the scoreboard predicts is the state the pixel path actually sees.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int unsigned CTRL_OFS = 32'h0000_0000;
  localparam int unsigned CFG_OFS  = 32'h0000_0004;
  localparam int unsigned STAT_OFS = 32'h0000_0008;
  localparam int unsigned WIN_BASE = 32'h0000_2000;

  function automatic bit depth_ok(int unsigned d);
    return (d == 256) || (d == 1024);
  endfunction
endpackage

// File: rtl/gamma_regs.sv
module gamma_regs #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned BPC   = $clog2(DEPTH),
  localparam int unsigned TAG_W = ADDR_W - BPC - 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [31:0]          wr_data_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [31:0]          rd_data_o,
  input  logic                 frame_start_i,
  output logic                 live_en_o,
  output logic                 live_bank_o,
  output logic                 tbl_we_o,
  output logic [BPC-1:0]       tbl_idx_o,
  output logic [3*BPC-1:0]     tbl_word_o
);
  import gamma_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] CFG_A   = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_OFS);
  localparam logic [TAG_W-1:0]  WIN_TAG = TAG_W'(WIN_BASE >> (BPC + 2));

  logic en_shadow_q, upd_q, armed_q, pend_en_q, pend_upd_q;
  logic live_en_q, bank_q;
  logic ctrl_hit, commit, apply, win_hit;

  assign ctrl_hit = wr_en_i && (wr_addr_i == CTRL_A);
  assign commit   = wr_en_i && (wr_addr_i == CFG_A) && wr_data_i[0];
  assign apply    = frame_start_i && armed_q;
  assign win_hit  = wr_en_i && (wr_addr_i[ADDR_W-1:BPC+2] == WIN_TAG);

  // table write port: word index from byte address, byte lanes ignored
  assign tbl_we_o   = win_hit;
  assign tbl_idx_o  = wr_addr_i[BPC+1:2];
  assign tbl_word_o = wr_data_i[3*BPC-1:0];

  logic unused_bits;
  assign unused_bits = ^{wr_addr_i[1:0], wr_data_i[31:3*BPC]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_shadow_q <= 1'b0;
      upd_q       <= 1'b0;
      armed_q     <= 1'b0;
      pend_en_q   <= 1'b0;
      pend_upd_q  <= 1'b0;
      live_en_q   <= 1'b0;
      bank_q      <= 1'b0;
    end else begin
      if (apply) begin
        live_en_q <= pend_en_q;
        armed_q   <= 1'b0;
        if (pend_upd_q) begin
          bank_q <= ~bank_q;
          upd_q  <= 1'b0;
        end
      end
      if (commit) begin
        armed_q    <= 1'b1;
        pend_en_q  <= en_shadow_q;
        pend_upd_q <= upd_q && !(apply && pend_upd_q);
      end
      if (ctrl_hit) begin
        en_shadow_q <= wr_data_i[0];
        if (wr_data_i[1]) upd_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      unique case (rd_addr_i)
        CTRL_A:  rd_data_o <= {30'b0, upd_q, en_shadow_q};
        STAT_A:  rd_data_o <= {31'b0, bank_q};
        default: rd_data_o <= '0;
      endcase
    end
  end

  assign live_en_o   = live_en_q;
  assign live_bank_o = bank_q;

  // R5: a committed update swaps the banks at the frame pulse
  a_r5_swap_on_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(apply && pend_upd_q) |-> (bank_q != $past(bank_q)));
  // R4: update bit cleared by hardware once the swap is done
  a_r4_upd_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(apply && pend_upd_q && !ctrl_hit) |-> !upd_q);
  // R6: the live enable changes only at a frame pulse
  a_r6_en_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_en_q != $past(live_en_q)) |-> $past(frame_start_i));
  // R10: no swap unless a commit was pending
  a_r10_no_swap_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(armed_q) |-> $stable(bank_q));
endmodule

// File: rtl/gamma_bank.sv
module gamma_bank #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned PORTS = 3,
  localparam int unsigned BPC  = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        we_i,
  input  logic [BPC-1:0]              widx_i,
  input  logic [3*BPC-1:0]            wword_i,
  input  logic [PORTS-1:0][BPC-1:0]   raddr_i,
  output logic [PORTS-1:0][BPC-1:0]   rfield_o
);
  logic [3*BPC-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[widx_i] <= wword_i;
  end

  // port k returns field k of the addressed word
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < PORTS; k++) begin
      rfield_o[k] <= mem[raddr_i[k]][k*BPC +: BPC];
    end
  end
endmodule

// File: rtl/gamma_pix.sv
module gamma_pix #(
  parameter int unsigned BPC = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 hs_i,
  input  logic                 vs_i,
  input  logic [2:0][BPC-1:0]  pix_i,
  input  logic                 live_en_i,
  input  logic                 live_bank_i,
  input  logic [2:0][BPC-1:0]  bank0_i,
  input  logic [2:0][BPC-1:0]  bank1_i,
  output logic                 vld_o,
  output logic                 hs_o,
  output logic                 vs_o,
  output logic [2:0][BPC-1:0]  pix_o
);
  logic                vld_q, hs_q, vs_q, en_q, bank_q;
  logic [2:0][BPC-1:0] raw_q;

  // matched one-cycle delay alongside the RAM read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      hs_q   <= 1'b0;
      vs_q   <= 1'b0;
      en_q   <= 1'b0;
      bank_q <= 1'b0;
      raw_q  <= '0;
    end else begin
      vld_q  <= vld_i;
      hs_q   <= hs_i;
      vs_q   <= vs_i;
      en_q   <= live_en_i;
      bank_q <= live_bank_i;
      raw_q  <= pix_i;
    end
  end

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      if (!en_q)       pix_o[c] = raw_q[c];
      else if (bank_q) pix_o[c] = bank1_i[c];
      else             pix_o[c] = bank0_i[c];
    end
  end

  assign vld_o = vld_q;
  assign hs_o  = hs_q;
  assign vs_o  = vs_q;
endmodule

// File: rtl/gamma_lut_dbuf.sv
module gamma_lut_dbuf #(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned LUT_DEPTH = 256,
  localparam int unsigned BPC      = $clog2(LUT_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              frame_start_i,
  input  logic              pix_vld_i,
  input  logic              pix_hs_i,
  input  logic              pix_vs_i,
  input  logic [BPC-1:0]    pix_r_i,
  input  logic [BPC-1:0]    pix_g_i,
  input  logic [BPC-1:0]    pix_b_i,
  output logic              pix_vld_o,
  output logic              pix_hs_o,
  output logic              pix_vs_o,
  output logic [BPC-1:0]    pix_r_o,
  output logic [BPC-1:0]    pix_g_o,
  output logic [BPC-1:0]    pix_b_o
);
  import gamma_pkg::*;

  // R9: only the two supported depths
  initial begin
    if (!depth_ok(LUT_DEPTH)) $error("gamma_lut_dbuf: unsupported LUT_DEPTH %0d", LUT_DEPTH);
  end

  logic                 live_en, live_bank;
  logic                 tbl_we;
  logic [BPC-1:0]       tbl_idx;
  logic [3*BPC-1:0]     tbl_word;
  logic [2:0][BPC-1:0]  pix_in, pix_out;
  logic [1:0][2:0][BPC-1:0] bank_rd;

  assign pix_in = {pix_r_i, pix_g_i, pix_b_i};

  gamma_regs #(.ADDR_W(ADDR_W), .DEPTH(LUT_DEPTH)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i(reg_wr_i), .wr_addr_i(reg_waddr_i), .wr_data_i(reg_wdata_i),
    .rd_en_i(reg_rd_i), .rd_addr_i(reg_raddr_i), .rd_data_o(reg_rdata_o),
    .frame_start_i,
    .live_en_o(live_en), .live_bank_o(live_bank),
    .tbl_we_o(tbl_we), .tbl_idx_o(tbl_idx), .tbl_word_o(tbl_word)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    gamma_bank #(.DEPTH(LUT_DEPTH), .PORTS(3)) u_bank (
      .clk_i,
      .we_i(tbl_we && (live_bank != 1'(b))),
      .widx_i(tbl_idx),
      .wword_i(tbl_word),
      .raddr_i(pix_in),
      .rfield_o(bank_rd[b])
    );
  end

  gamma_pix #(.BPC(BPC)) u_pix (
    .clk_i, .rst_ni,
    .vld_i(pix_vld_i), .hs_i(pix_hs_i), .vs_i(pix_vs_i), .pix_i(pix_in),
    .live_en_i(live_en), .live_bank_i(live_bank),
    .bank0_i(bank_rd[0]), .bank1_i(bank_rd[1]),
    .vld_o(pix_vld_o), .hs_o(pix_hs_o), .vs_o(pix_vs_o), .pix_o(pix_out)
  );

  assign {pix_r_o, pix_g_o, pix_b_o} = pix_out;

  // R8: valid and sync arrive one cycle after the input
  a_r8_sync_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pix_vld_i) |-> (pix_vld_o && pix_hs_o == $past(pix_hs_i) && pix_vs_o == $past(pix_vs_i)));
  // R2: bypass returns the input pixel unchanged
  a_r2_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pix_vld_i && !live_en) |->
      (pix_r_o == $past(pix_r_i) && pix_g_o == $past(pix_g_i) && pix_b_o == $past(pix_b_i)));
endmodule

// File: tb/gamma_lut_dbuf_tb.sv
`timescale 1ns/1ps
module gamma_lut_dbuf_tb;
  localparam int ADDR_W = 14;
  localparam int DEPTH  = 256;
  localparam int BPC    = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              reg_wr = 0, reg_rd = 0, frame = 0;
  logic [ADDR_W-1:0] waddr = '0, raddr = '0;
  logic [31:0]       wdata = '0, rdata;
  logic              vld_i = 0, hs_i = 0, vs_i = 0;
  logic [BPC-1:0]    r_i = 0, g_i = 0, b_i = 0;
  logic              vld_o, hs_o, vs_o;
  logic [BPC-1:0]    r_o, g_o, b_o;

  gamma_lut_dbuf #(.ADDR_W(ADDR_W), .LUT_DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_rd_i(reg_rd), .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .frame_start_i(frame),
    .pix_vld_i(vld_i), .pix_hs_i(hs_i), .pix_vs_i(vs_i),
    .pix_r_i(r_i), .pix_g_i(g_i), .pix_b_i(b_i),
    .pix_vld_o(vld_o), .pix_hs_o(hs_o), .pix_vs_o(vs_o),
    .pix_r_o(r_o), .pix_g_o(g_o), .pix_b_o(b_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model: two banks, live bank, live enable
  logic [23:0] mdl [2][DEPTH];
  int  live_bank = 0;
  bit  live_en = 0;

  typedef struct packed { logic hs; logic vs; logic [7:0] r; logic [7:0] g; logic [7:0] b; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(int unsigned a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; waddr = ADDR_W'(a); wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(int unsigned a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; raddr = ADDR_W'(a);
    @(negedge clk); reg_rd = 0; d = rdata;
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame = 1;
    @(negedge clk); frame = 0;
  endtask

  // driver: drives one pixel, pushes expected result
  task automatic send(logic [7:0] r, logic [7:0] g, logic [7:0] b, logic hs, logic vs, string tag);
    exp_t e;
    @(negedge clk);
    vld_i = 1; r_i = r; g_i = g; b_i = b; hs_i = hs; vs_i = vs;
    e.hs = hs; e.vs = vs;
    if (live_en) begin
      e.r = mdl[live_bank][r][23:16];
      e.g = mdl[live_bank][g][15:8];
      e.b = mdl[live_bank][b][7:0];
    end else begin
      e.r = r; e.g = g; e.b = b;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic burst(int n, int seed, string tag);
    for (int i = 0; i < n; i++)
      send(8'(i*7 + seed), 8'(i*13 + 5 + seed), 8'(255 - i - seed), (i % 4) == 0, i == 0, tag);
    send(8'd255, 8'd0, 8'd255, 1'b0, 1'b0, tag);
    @(negedge clk); vld_i = 0;
    repeat (3) @(negedge clk);
  endtask

  // monitor: pops and compares every valid output
  always @(negedge clk) begin
    if (rst_n && vld_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected output valid actual=1 expected=0");
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " pixel"}, {8'h0, r_o, g_o, b_o}, {8'h0, e.r, e.g, e.b});
        chk("R8 sync", {30'b0, hs_o, vs_o}, {30'b0, e.hs, e.vs});
      end
    end
  end

  function automatic logic [23:0] fill_a(int i);
    return {8'(~i), 8'(i ^ 8'h5a), 8'(i + 1)};
  endfunction
  function automatic logic [23:0] fill_b(int i);
    return {8'(i * 3), 8'(~i), 8'(i ^ 8'ha5)};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk("R1 valid", {31'b0, vld_o}, 0);
    rd(32'h008, d); chk("R1 stat", d, 0);
    rd(32'h000, d); chk("R1 ctrl", d, 0);

    // R2: bypass after reset
    burst(8, 0, "R2 bypass");

    // R3: fill shadow bank 1 including last entry (R9)
    for (int i = 0; i < DEPTH; i++) begin
      wr(32'h2000 + 4*i, {8'h0, fill_a(i)});
      mdl[1][i] = fill_a(i);
    end
    burst(6, 3, "R3 shadow write no effect");

    // R4/R6: stage enable+update, no commit yet
    wr(32'h000, 32'h3);
    rd(32'h000, d); chk("R4 upd set", d, 3);
    pulse_frame();
    // R10: frame without commit
    rd(32'h008, d); chk("R10 stat unchanged", d, 0);
    rd(32'h000, d); chk("R10 upd kept", d, 3);
    burst(5, 9, "R6 staged not live");

    // R4: writing 0 to update bit does not clear it
    wr(32'h000, 32'h1);
    rd(32'h000, d); chk("R4 upd sticky", d, 3);

    // R6: commit alone has no effect
    wr(32'h004, 32'h1);
    rd(32'h008, d); chk("R6 commit no swap", d, 0);
    burst(5, 11, "R6 commit only");

    // R5: swap at frame
    pulse_frame();
    live_bank = 1; live_en = 1;
    rd(32'h008, d); chk("R5 stat toggled", d, 1);
    rd(32'h000, d); chk("R4 upd cleared", d, 1);
    burst(20, 1, "R7 corrected bank1");
    send(8'd255, 8'd255, 8'd255, 1'b1, 1'b1, "R9 last entry");
    @(negedge clk); vld_i = 0;
    repeat (3) @(negedge clk);

    // R3: rewrite bank 0 while bank 1 is live
    for (int i = 0; i < DEPTH; i++) begin
      wr(32'h2000 + 4*i, {8'h0, fill_b(i)});
      mdl[0][i] = fill_b(i);
    end
    burst(10, 4, "R3 live bank untouched");

    // R5: swap back to bank 0
    wr(32'h000, 32'h3);
    wr(32'h004, 32'h1);
    pulse_frame();
    live_bank = 0;
    rd(32'h008, d); chk("R5 stat back", d, 0);
    burst(20, 2, "R7 corrected bank0");

    // R2: disable, no update
    wr(32'h000, 32'h0);
    wr(32'h004, 32'h1);
    burst(4, 6, "R6 enable staged");
    pulse_frame();
    live_en = 0;
    rd(32'h008, d); chk("R2 stat kept", d, 0);
    burst(10, 8, "R2 bypass again");

    repeat (5) @(negedge clk);
    chk("R8 drained", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule